// File: doc/BRIEF.md
# Horizontal Microcode Sequencer

This block is the control unit of a simple data path in which every operation takes a single bus cycle. It keeps a writable store of wide microwords and a microprogram counter. In each cycle it reads the word the counter points at and splits it into field groups. The ALU/shifter code, the register-write strobes and the memory commands go straight to the outputs. The encoded B-bus source is expanded into one enable line per register. The successor address is formed from the word's own next-address field, the data path's negative and zero flags, and the byte most recently fetched from the instruction stream.

The counter is never incremented. Every microword names its own successor. A condition can only force the successor's top bit to 1, so a two-way branch always lands on a pair of addresses that differ only in the MSB. A dispatch flag ORs the fetched byte into the low address bits, which gives a multiway jump on opcode.

The store is programmed through a write port that only works while the block is held in reset. Execution begins at address 0 in the cycle after the first clock edge that sees reset low.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst` is high, and during the first cycle after it falls, `mpc` is 0 and every control output (`alu_ctl`, `c_wr`, `b_en`, `mem_rd`, `mem_wr`, `mem_fetch`) is 0.
- R2: The first microword executed is the one at address 0. It drives the outputs from the cycle after the first rising edge at which `rst` is low.
- R3: Microword layout (36 bits): successor address [35:27], jump flags [26:24], ALU/shifter code [23:16], register-write strobes [15:7], memory [6:4], B source [3:0]. `alu_ctl` equals bits [23:16] and `c_wr` equals bits [15:7], with any number of strobes high at once. `mem_wr` is bit 6, `mem_rd` is bit 5 and `mem_fetch` is bit 4.
- R4: A B-source code v from 0 to 8 drives only `b_en[v]` high. Codes 9 to 15 drive no `b_en` line.
- R5: With all jump flags clear, `next_mpc` equals the successor field exactly, whatever the flag and byte inputs are. Execution follows that field and never the current address plus one.
- R6: With the zero-test flag (bit 24) set, `next_mpc[8]` is forced to 1 when `alu_z` is 1.
- R7: With the negative-test flag (bit 25) set, `next_mpc[8]` is forced to 1 when `alu_n` is 1.
- R8: With the dispatch flag (bit 26) set, `next_mpc[7:0]` is the bitwise OR of the successor's low 8 bits and `mbr_byte`.
- R9: The flags and byte present at a rising edge decide the address executed next. `mpc` after the edge equals `next_mpc` just before it.
- R10: A store write with `rst` low has no effect. The word at that address is unchanged both while running and after a later reset.
- R11: When the successor field's top bit is already 1, `next_mpc[8]` stays 1 whatever the conditions are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the store can be written only while it is high |
| cs_we | input | 1 | Control store write enable |
| cs_waddr | input | 9 | Control store write address |
| cs_wdata | input | 36 | Microword to write |
| alu_n | input | 1 | Negative flag of the current ALU result |
| alu_z | input | 1 | Zero flag of the current ALU result |
| mbr_byte | input | 8 | Byte last fetched from the instruction stream |
| alu_ctl | output | 8 | ALU and shifter control code |
| c_wr | output | 9 | Register write strobes from the C bus |
| b_en | output | 9 | One-hot B-bus driver enables |
| mem_rd | output | 1 | Word read command |
| mem_wr | output | 1 | Word write command |
| mem_fetch | output | 1 | Byte fetch command |
| mpc | output | 9 | Address of the microword now executing |
| next_mpc | output | 9 | Address that will execute next |

## Verification
The hardest case to reach is a branch whose outcome depends on flags and a byte that arrive in the same cycle as the word that tests them. The stimulus has to load the word, release reset, and hold the flag and byte values across exactly one edge. To do this, each table vector reloads address 0 under reset and sets the flags and byte before release. It then checks `next_mpc` during the executing cycle and `mpc` after the edge. The write-port lockout is reached by writing to the live address mid-run and re-running that address after a reset that has no write.

// File: rtl/micro_sequencer.sv
module micro_sequencer #(
  parameter int ADDR_W = 9,
  parameter int ALU_W  = 8,
  parameter int REG_N  = 9,
  localparam int JAM_W  = 3,
  localparam int MEM_W  = 3,
  localparam int SEL_W  = $clog2(REG_N),
  localparam int WORD_W = ADDR_W + JAM_W + ALU_W + REG_N + MEM_W + SEL_W,
  localparam int LOW_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_we,
  input  logic [ADDR_W-1:0] cs_waddr,
  input  logic [WORD_W-1:0] cs_wdata,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic [LOW_W-1:0]  mbr_byte,
  output logic [ALU_W-1:0]  alu_ctl,
  output logic [REG_N-1:0]  c_wr,
  output logic [REG_N-1:0]  b_en,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_fetch,
  output logic [ADDR_W-1:0] mpc,
  output logic [ADDR_W-1:0] next_mpc
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MEM_LSB  = SEL_W;
  localparam int C_LSB    = MEM_LSB + MEM_W;
  localparam int ALU_LSB  = C_LSB + REG_N;
  localparam int JAM_LSB  = ALU_LSB + ALU_W;
  localparam int ADDR_LSB = JAM_LSB + JAM_W;

  logic [WORD_W-1:0] store [DEPTH];
  logic              run;
  logic [ADDR_W-1:0] mpc_q;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] succ;
  logic              jmpc, jamn, jamz;
  logic [SEL_W-1:0]  b_sel;

  always_ff @(posedge clk)
    if (rst && cs_we) store[cs_waddr] <= cs_wdata;

  always_ff @(posedge clk)
    if (rst) begin
      run   <= 1'b0;
      mpc_q <= '0;
    end else begin
      run <= 1'b1;
      if (run) mpc_q <= next_mpc;
    end

  assign word  = run ? store[mpc_q] : '0;
  assign succ  = word[ADDR_LSB +: ADDR_W];
  assign jmpc  = word[JAM_LSB + 2];
  assign jamn  = word[JAM_LSB + 1];
  assign jamz  = word[JAM_LSB];
  assign b_sel = word[SEL_W-1:0];

  assign alu_ctl   = word[ALU_LSB +: ALU_W];
  assign c_wr      = word[C_LSB +: REG_N];
  assign mem_wr    = word[MEM_LSB + 2];
  assign mem_rd    = word[MEM_LSB + 1];
  assign mem_fetch = word[MEM_LSB];
  assign mpc       = mpc_q;

  assign next_mpc[ADDR_W-1]  = succ[ADDR_W-1] | (jamz & alu_z) | (jamn & alu_n);
  assign next_mpc[LOW_W-1:0] = succ[LOW_W-1:0] | (jmpc ? mbr_byte : '0);

  for (genvar i = 0; i < REG_N; i++) begin : g_bdec
    assign b_en[i] = run && (b_sel == SEL_W'(i));
  end

  a_r1_quiet_until_run: assert property (@(posedge clk) disable iff (rst)
    !run |-> (alu_ctl == '0 && c_wr == '0 && b_en == '0 && !mem_rd && !mem_wr && !mem_fetch));

  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mpc == '0 && !run));

  a_r4_b_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b_en));

  a_r5_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
    !jmpc |-> next_mpc[LOW_W-1:0] == succ[LOW_W-1:0]);

  a_r9_mpc_follows: assert property (@(posedge clk) disable iff (rst)
    run |=> mpc == $past(next_mpc));

  a_r11_top_sticky: assert property (@(posedge clk) disable iff (rst)
    succ[ADDR_W-1] |-> next_mpc[ADDR_W-1]);
endmodule

// File: tb/micro_sequencer_test.sv
module micro_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_we = 1'b0;
  logic [8:0]  cs_waddr = '0;
  logic [35:0] cs_wdata = '0;
  logic        alu_n = 1'b0, alu_z = 1'b0;
  logic [7:0]  mbr_byte = '0;
  logic [7:0]  alu_ctl;
  logic [8:0]  c_wr, b_en, mpc, next_mpc;
  logic        mem_rd, mem_wr, mem_fetch;

  int checks = 0;
  int errors = 0;

  micro_sequencer uut (
    .clk(clk), .rst(rst), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .alu_n(alu_n), .alu_z(alu_z), .mbr_byte(mbr_byte),
    .alu_ctl(alu_ctl), .c_wr(c_wr), .b_en(b_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_fetch(mem_fetch),
    .mpc(mpc), .next_mpc(next_mpc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {successor, jump flags (dispatch,neg,zero), n, z, byte, expected next}
  localparam logic [30:0] VEC [10] = '{
    {9'h005, 3'b000, 1'b1, 1'b1, 8'hFF, 9'h005},  // R5
    {9'h023, 3'b001, 1'b0, 1'b1, 8'h00, 9'h123},  // R6 taken
    {9'h023, 3'b001, 1'b1, 1'b0, 8'h00, 9'h023},  // R6 not taken
    {9'h040, 3'b010, 1'b1, 1'b0, 8'h00, 9'h140},  // R7 taken
    {9'h040, 3'b010, 1'b0, 1'b1, 8'h00, 9'h040},  // R7 not taken
    {9'h100, 3'b100, 1'b0, 1'b0, 8'h5A, 9'h15A},  // R8
    {9'h0F0, 3'b100, 1'b0, 1'b0, 8'h0F, 9'h0FF},  // R8
    {9'h1AB, 3'b001, 1'b0, 1'b1, 8'h00, 9'h1AB},  // R11
    {9'h000, 3'b101, 1'b0, 1'b1, 8'h3C, 9'h13C},  // R6 + R8
    {9'h081, 3'b100, 1'b0, 1'b0, 8'h81, 9'h081}   // R8 OR, not add
  };

  function automatic logic [35:0] mk(logic [8:0] a, logic [2:0] j, logic [7:0] alu,
                                     logic [8:0] c, logic [2:0] m, logic [3:0] b);
    return {a, j, alu, c, m, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(logic [8:0] a, logic [35:0] w);
    @(negedge clk);
    rst = 1'b1; cs_we = 1'b1; cs_waddr = a; cs_wdata = w;
    @(negedge clk);
    cs_we = 1'b0;
  endtask

  task automatic start();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic quiet(string req);
    check(req, {mpc, alu_ctl, c_wr, b_en, mem_rd, mem_wr, mem_fetch}, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: quiet during reset, even with a word stored at address 0
    load(9'h000, mk(9'h002, 3'b000, 8'hEE, 9'h1FF, 3'b111, 4'h2));
    #1 quiet("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    #1 quiet("R1 release cycle");
    @(negedge clk);
    #1 check("R2 first word", {mpc, alu_ctl}, {9'h000, 8'hEE});

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < 10; i++) begin
      logic [7:0] a = 8'(8'h13 * (i + 1));
      logic [8:0] c = 9'(9'h101 | (9'h001 << i));
      logic [2:0] m = 3'(i + 1);
      load(9'h000, mk(VEC[i][30:22], VEC[i][21:19], a, c, m, 4'(i)));
      alu_n = VEC[i][18]; alu_z = VEC[i][17]; mbr_byte = VEC[i][16:9];
      start();
      #1;
      check("R5/R6/R7/R8/R11 next_mpc", next_mpc, VEC[i][8:0]);
      check("R3 alu_ctl", alu_ctl, a);
      check("R3 c_wr", c_wr, c);
      check("R3 mem", {mem_wr, mem_rd, mem_fetch}, m);
      check("R4 b_en", b_en, (i < 9) ? 9'(9'h001 << i) : 9'h000);
      @(negedge clk);
      #1 check("R9 mpc after edge", mpc, VEC[i][8:0]);
    end
    alu_n = 1'b0; alu_z = 1'b0; mbr_byte = '0;

    // R4: every B code
    for (int v = 0; v < 16; v++) begin
      load(9'h000, mk(9'h000, 3'b000, 8'h00, 9'h000, 3'b000, 4'(v)));
      start();
      #1 check("R4 b decode", b_en, (v < 9) ? 9'(9'h001 << v) : 9'h000);
    end

    // R2 / R5: explicit successors, no increment
    load(9'h000, mk(9'h007, 3'b000, 8'hA1, 9'h000, 3'b000, 4'hF));
    load(9'h007, mk(9'h1F0, 3'b000, 8'hA2, 9'h000, 3'b000, 4'hF));
    load(9'h1F0, mk(9'h000, 3'b000, 8'hA3, 9'h000, 3'b000, 4'hF));
    start();
    #1 check("R2 chain step 0", {mpc, alu_ctl}, {9'h000, 8'hA1});
    @(negedge clk);
    #1 check("R5 chain step 1", {mpc, alu_ctl}, {9'h007, 8'hA2});
    @(negedge clk);
    #1 check("R5 chain step 2", {mpc, alu_ctl}, {9'h1F0, 8'hA3});
    @(negedge clk);
    #1 check("R5 chain wrap", {mpc, alu_ctl}, {9'h000, 8'hA1});

    // R10: writes while running are ignored
    load(9'h000, mk(9'h000, 3'b000, 8'h3C, 9'h000, 3'b000, 4'hF));
    start();
    cs_we = 1'b1; cs_waddr = 9'h000; cs_wdata = mk(9'h000, 3'b000, 8'hC3, 9'h000, 3'b000, 4'hF);
    @(negedge clk);
    cs_we = 1'b0;
    #1 check("R10 while running", alu_ctl, 8'h3C);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 check("R10 after reset", alu_ctl, 8'h3C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule